// File: doc/BRIEF.md
# Counted Serial Frame Loader

This controller feeds a 16-bit serial-capable DAC input register from only three incoming lines: a serial data bit, a data strobe and a reset request. All three arrive asynchronously. They are synchronised to the system clock, and each rising edge of the strobe becomes a single one-clock write pulse towards the DAC register. The data bit captured with that edge is presented on the serial data output for the whole pulse. Both byte-latch enables of the register are tied active so that it always shifts serially.

There is no framing or select signal. A binary counter that is as wide as log2 of the word length counts the write pulses. On the pulse that carries the last bit of a word, the counter's terminal carry drives the transfer enable low. The final shift and the parallel copy into the D/A latch therefore share one write edge. The counter wraps to zero on its own, so words can follow each other with no gap. A raised reset line clears the counter, holds the DAC clear output active and blocks all writes. A one-clock completion pulse follows every transfer.

Top module: `serial_frame_loader`

## Requirements
- R1: Both byte-latch enable outputs (`dac_lo_en_n_o`, `dac_hi_en_n_o`) are 0 at all times, in reset and in operation.
- R2: Each rising strobe edge produces exactly one write pulse: `dac_wr_n_o` is 0 for exactly one clock, starting in the third clock edge after the strobe rises, and it is 1 otherwise.
- R3: During each write pulse, `dac_sdata_o` equals the data bit that was present with the strobe edge. Bits are sent most significant first, so shifting them in yields the transmitted word.
- R4: `dac_xfer_n_o` is 0 only during the write pulse for the 16th, 32nd, … strobe counted since the last clear. It is 1 at all other times.
- R5: The strobe counter wraps after 16 strobes. Consecutive words sent back to back each produce their own transfer of the correct word, without resynchronisation.
- R6: `word_done_o` is 1 for exactly the one clock that follows each write pulse in which the transfer enable was active, and it is 0 otherwise.
- R7: While the synchronised reset line is high, `dac_clr_n_o` is 0 (it becomes valid three clock edges after the line changes), and strobes produce no write pulse.
- R8: A reset during a partly sent word discards the partial count, so the next 16 strobes after the reset is released form a complete word.
- R9: While `rst_n` is low: `dac_wr_n_o`=1, `dac_xfer_n_o`=1, `dac_clr_n_o`=0, `word_done_o`=0.
- R10: A falling strobe edge produces no write pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| ser_data_i | input | 1 | Serial data bit, MSB first, asynchronous |
| ser_strobe_i | input | 1 | Data strobe; each rising edge moves one bit, asynchronous |
| ser_reset_i | input | 1 | Active-high reset request line, asynchronous |
| dac_sdata_o | output | 1 | Serial data bit for the DAC register |
| dac_wr_n_o | output | 1 | Active-low write pulse to the DAC register |
| dac_lo_en_n_o | output | 1 | Low-byte latch enable, held active (0) |
| dac_hi_en_n_o | output | 1 | High-byte latch enable, held active (0) |
| dac_xfer_n_o | output | 1 | Active-low D/A latch transfer enable |
| dac_clr_n_o | output | 1 | Active-low DAC clear |
| word_done_o | output | 1 | One-clock pulse after each completed transfer |

## Verification
A wrong strobe count shows at the ports within one word. The transfer enable lands on the wrong write pulse, so the word assembled from the serial output differs from the word sent, and `word_done_o` fires out of place no later than the 16th strobe. A stale edge-detect or sync stage shows as a missing, doubled or mistimed write pulse on the very next strobe, because the pulse is checked at the exact third clock edge. A counter that survives reset shows as a transfer at the wrong bit of the first word after the reset is released.

// File: rtl/ser_ldr_pkg.sv
package ser_ldr_pkg;

    // Registered output state of the loader
    typedef struct packed {
        logic stb_prev;   // previous synchronised strobe, for edge detect
        logic wr_n;       // write pulse to DAC register
        logic xfer_n;     // D/A latch transfer enable
        logic sdat;       // serial data bit presented with the write
        logic clr_n;      // DAC clear
        logic done;       // transfer completed pulse
    } ldr_state_t;

    localparam ldr_state_t LDR_RESET = '{
        stb_prev: 1'b0,
        wr_n:     1'b1,
        xfer_n:   1'b1,
        sdat:     1'b0,
        clr_n:    1'b0,
        done:     1'b0
    };

endpackage

// File: rtl/sync_chain.sv
module sync_chain #(
    parameter int STAGES = 2,
    parameter int WIDTH  = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [WIDTH-1:0] stg_d [STAGES];
    logic [WIDTH-1:0] stg_q [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_comb stg_d[g] = async_i;
            end else begin : g_rest
                always_comb stg_d[g] = stg_q[g-1];
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg_q[g] <= '0;
                else        stg_q[g] <= stg_d[g];
            end
        end
    endgenerate

    assign sync_o = stg_q[STAGES-1];

endmodule

// File: rtl/frame_counter.sv
module frame_counter #(
    parameter int WORD_BITS = 16,
    localparam int CNT_W    = $clog2(WORD_BITS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             inc_i,
    output logic [CNT_W-1:0] count_o,
    output logic             carry_o
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_BITS - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i) begin
            cnt_d = '0;
        end else if (inc_i) begin
            cnt_d = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign count_o = cnt_q;
    // Terminal carry: the increment that completes a word
    assign carry_o = inc_i && !clr_i && (cnt_q == LAST);

endmodule

// File: rtl/serial_frame_loader.sv
module serial_frame_loader
    import ser_ldr_pkg::*;
#(
    parameter int WORD_BITS   = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ser_data_i,
    input  logic ser_strobe_i,
    input  logic ser_reset_i,
    output logic dac_sdata_o,
    output logic dac_wr_n_o,
    output logic dac_lo_en_n_o,
    output logic dac_hi_en_n_o,
    output logic dac_xfer_n_o,
    output logic dac_clr_n_o,
    output logic word_done_o
);

    localparam int CNT_W = $clog2(WORD_BITS);
    localparam int IN_W  = 3;

    logic [IN_W-1:0]  raw_in;
    logic [IN_W-1:0]  syn_in;
    logic             rst_s, stb_s, dat_s;
    logic             stb_rise, fire;
    logic [CNT_W-1:0] bit_cnt;
    logic             word_carry;

    ldr_state_t st_d, st_q;

    assign raw_in = {ser_reset_i, ser_strobe_i, ser_data_i};

    sync_chain #(
        .STAGES (SYNC_STAGES),
        .WIDTH  (IN_W)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (raw_in),
        .sync_o  (syn_in)
    );

    assign rst_s = syn_in[2];
    assign stb_s = syn_in[1];
    assign dat_s = syn_in[0];

    assign stb_rise = stb_s && !st_q.stb_prev;
    assign fire     = stb_rise && !rst_s;

    frame_counter #(
        .WORD_BITS (WORD_BITS)
    ) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (rst_s),
        .inc_i   (fire),
        .count_o (bit_cnt),
        .carry_o (word_carry)
    );

    always_comb begin
        st_d          = st_q;
        st_d.stb_prev = stb_s;
        st_d.wr_n     = !fire;
        st_d.xfer_n   = !(fire && word_carry);
        st_d.sdat     = fire ? dat_s : st_q.sdat;
        st_d.clr_n    = !rst_s;
        st_d.done     = !st_q.xfer_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= LDR_RESET;
        else        st_q <= st_d;
    end

    assign dac_sdata_o   = st_q.sdat;
    assign dac_wr_n_o    = st_q.wr_n;
    assign dac_xfer_n_o  = st_q.xfer_n;
    assign dac_clr_n_o   = st_q.clr_n;
    assign word_done_o   = st_q.done;
    assign dac_lo_en_n_o = 1'b0;
    assign dac_hi_en_n_o = 1'b0;

endmodule

// File: rtl/serial_frame_loader_chk.sv
module serial_frame_loader_chk #(
    parameter int WORD_BITS = 16
) (
    input logic clk,
    input logic rst_n,
    input logic dac_wr_n_o,
    input logic dac_xfer_n_o,
    input logic dac_clr_n_o,
    input logic word_done_o
);

    localparam int CNT_W = $clog2(WORD_BITS);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_BITS - 1);

    // Independent count of write pulses since the last clear
    logic [CNT_W-1:0] wr_seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           wr_seen <= '0;
        else if (!dac_clr_n_o) wr_seen <= '0;
        else if (!dac_wr_n_o)  wr_seen <= wr_seen + 1'b1;
    end

    // R2
    wr_pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dac_wr_n_o |=> dac_wr_n_o);

    // R4
    xfer_inside_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dac_xfer_n_o |-> !dac_wr_n_o);

    // R4
    xfer_on_last_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dac_wr_n_o |-> (dac_xfer_n_o == (wr_seen != LAST)));

    // R6
    done_follows_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_done_o |-> !$past(dac_xfer_n_o));

    // R6
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_done_o |=> !word_done_o);

    // R7
    no_write_in_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dac_clr_n_o |-> dac_wr_n_o);

endmodule

bind serial_frame_loader serial_frame_loader_chk #(
    .WORD_BITS (WORD_BITS)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .dac_wr_n_o   (dac_wr_n_o),
    .dac_xfer_n_o (dac_xfer_n_o),
    .dac_clr_n_o  (dac_clr_n_o),
    .word_done_o  (word_done_o)
);

// File: tb/tb_serial_frame_loader.sv
`timescale 1ns/1ps
module tb_serial_frame_loader;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_data = 1'b0;
    logic ser_strobe = 1'b0;
    logic ser_reset = 1'b0;
    logic dac_sdata_o, dac_wr_n_o, dac_lo_en_n_o, dac_hi_en_n_o;
    logic dac_xfer_n_o, dac_clr_n_o, word_done_o;

    int tests = 0;
    int fails = 0;
    bit finished = 1'b0;
    int bit_idx = 0;
    logic [15:0] shreg = '0;
    logic [15:0] cur_word = '0;

    always #10 clk = ~clk;

    serial_frame_loader dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .ser_data_i    (ser_data),
        .ser_strobe_i  (ser_strobe),
        .ser_reset_i   (ser_reset),
        .dac_sdata_o   (dac_sdata_o),
        .dac_wr_n_o    (dac_wr_n_o),
        .dac_lo_en_n_o (dac_lo_en_n_o),
        .dac_hi_en_n_o (dac_hi_en_n_o),
        .dac_xfer_n_o  (dac_xfer_n_o),
        .dac_clr_n_o   (dac_clr_n_o),
        .word_done_o   (word_done_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // One strobe cycle: rise with data, check write pulse, fall, check quiet
    task automatic send_bit(input logic b);
        bit exp_x;
        ser_data   = b;
        ser_strobe = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        exp_x = (bit_idx == 15);
        check(dac_wr_n_o == 1'b0, "R2 write pulse low", dac_wr_n_o, 0);
        check(dac_sdata_o == b, "R3 serial bit", dac_sdata_o, b);
        check(dac_xfer_n_o == !exp_x, "R4 transfer enable", dac_xfer_n_o, !exp_x);
        shreg = {shreg[14:0], dac_sdata_o};
        @(negedge clk);
        check(dac_wr_n_o == 1'b1, "R2 pulse one clock", dac_wr_n_o, 1);
        check(dac_xfer_n_o == 1'b1, "R4 transfer released", dac_xfer_n_o, 1);
        check(word_done_o == exp_x, "R6 done pulse", word_done_o, exp_x);
        if (exp_x)
            check(shreg == cur_word, "R5 word transferred", shreg, cur_word);
        bit_idx = (bit_idx + 1) % 16;
        ser_strobe = 1'b0;
        repeat (4) begin
            @(negedge clk);
            check(dac_wr_n_o == 1'b1, "R10 no write on falling strobe", dac_wr_n_o, 1);
            check(word_done_o == 1'b0, "R6 done single clock", word_done_o, 0);
        end
    endtask

    task automatic send_word(input logic [15:0] w);
        cur_word = w;
        for (int i = 15; i >= 0; i--) send_bit(w[i]);
    endtask

    initial begin
        // R9: reset state
        repeat (3) @(negedge clk);
        check(dac_wr_n_o == 1'b1, "R9 wr idle", dac_wr_n_o, 1);
        check(dac_xfer_n_o == 1'b1, "R9 xfer idle", dac_xfer_n_o, 1);
        check(dac_clr_n_o == 1'b0, "R9 clear active", dac_clr_n_o, 0);
        check(word_done_o == 1'b0, "R9 done idle", word_done_o, 0);
        check(dac_lo_en_n_o == 1'b0, "R1 lo enable", dac_lo_en_n_o, 0);
        check(dac_hi_en_n_o == 1'b0, "R1 hi enable", dac_hi_en_n_o, 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check(dac_clr_n_o == 1'b1, "R7 clear released", dac_clr_n_o, 1);

        // Fixed patterns, back to back (R5)
        send_word(16'h0000);
        send_word(16'hFFFF);
        send_word(16'hA5C3);
        send_word(16'h8001);
        send_word(16'h7FFE);
        // Walking ones
        for (int k = 0; k < 16; k++) send_word(16'(1) << k);
        // Arithmetic sweep
        for (int k = 0; k < 8; k++) send_word(16'(k * 16'h2F1B + 16'h0137));

        check(dac_lo_en_n_o == 1'b0 && dac_hi_en_n_o == 1'b0, "R1 enables after traffic",
              {dac_hi_en_n_o, dac_lo_en_n_o}, 0);

        // R8: partial word then reset
        cur_word = 16'h1234;
        for (int i = 15; i >= 11; i--) send_bit(cur_word[i]);
        ser_reset = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check(dac_clr_n_o == 1'b1, "R7 clear latency", dac_clr_n_o, 1);
        @(posedge clk);
        @(negedge clk);
        check(dac_clr_n_o == 1'b0, "R7 clear asserted", dac_clr_n_o, 0);
        // R7: strobes ignored while reset is held
        for (int p = 0; p < 3; p++) begin
            ser_strobe = 1'b1;
            ser_data = 1'b1;
            repeat (4) begin
                @(negedge clk);
                check(dac_wr_n_o == 1'b1, "R7 no write in reset", dac_wr_n_o, 1);
            end
            ser_strobe = 1'b0;
            repeat (4) begin
                @(negedge clk);
                check(dac_wr_n_o == 1'b1, "R7 no write in reset", dac_wr_n_o, 1);
            end
        end
        ser_reset = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(dac_clr_n_o == 1'b1, "R7 clear released", dac_clr_n_o, 1);
        bit_idx = 0;
        send_word(16'hC0DE);   // R8: full word after reset
        send_word(16'h5AA5);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(20 * 150000);
        if (!finished) begin
            tests++;
            fails++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule